// File: doc/BRIEF.md
# Wakeup Pending Clear Source Selector

This block keeps one wakeup pending flag per line for an always-on power domain and drives it out as the domain wakeup signal. Each line is either a configurable line, set by a single-cycle trigger pulse, or a direct line, set while a level input is high. The split is fixed at build time by a parameter mask.

How a pending flag is released is programmable per line. With the line's clear-by-event enable at 0 the flag releases on its own. A configurable line drops a fixed number of clock cycles after its trigger. A direct line drops once its level input goes low. With the enable at 1 the flag is held until one of four external clear-event strobes fires, and a 2-bit source code per line chooses which strobe. A small register port writes and reads the enables and codes, and it can return any set of lines to their default configuration.

Top module: `wkup_clear_sel`

## Requirements
- R1: After reset every wakeup output is 0, every enable is 0 and every 2-bit source code is 00.
- R2: A trigger pulse on a configurable line, or a high level on a direct line, sets that line's wakeup output on the next clock edge. A trigger that coincides with a selected clear strobe wins, and the output stays 1.
- R3: With the enable at 0, a configurable line's wakeup output stays 1 for exactly AUTO_DLY cycles after its trigger edge and then drops. A new trigger while the line is pending restarts the full delay.
- R4: With the enable at 0, a direct line's wakeup output stays 1 while the level is high, however long that is. It drops on the edge after the level goes low.
- R5: With the enable at 1, source code c (0 to 3) selects clear strobe c. While the line is pending, that strobe drops the output on the next edge, and the other three strobes have no effect.
- R6: With the enable at 1, a direct line stays pending after its level goes low until the selected strobe fires.
- R7: Clear strobes that arrive while a line is not pending leave its output at 0.
- R8: Register 0 holds the enables, with line n at bit n. Register 1 holds the codes of lines 0 to 15 and register 2 holds the codes of lines 16 to 31, with line n at bits 2*(n mod 16)+1 : 2*(n mod 16). All three read back what was written.
- R9: Writing register 3 with bit n set returns line n to enable 0 and code 00. Lines whose bit is 0 keep their configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_pulse | input | NLINES | Trigger pulses for the configurable lines; ignored on direct lines |
| direct_lvl | input | NLINES | Level inputs for the direct lines; ignored on configurable lines |
| clr_evt | input | 4 | External clear-event strobes, indexed by source code |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select: 0 enables, 1 low codes, 2 high codes, 3 configuration clear |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr, combinational; register 3 reads 0 |
| wake | output | NLINES | Per-line domain wakeup signal |

## Verification
A trigger and a selected clear strobe can fall in the same cycle on a pending line. The bench forces this on every configurable line under every source code by driving both in the same cycle. It then expects the output to stay 1, and to drop only on a later strobe that comes alone. The bench also sweeps every line through all four codes, firing the three unselected strobes first and then the selected one. It times the automatic release against AUTO_DLY and against the direct level.

// File: rtl/wkup_clear_sel.sv
module wkup_clear_sel #(
  parameter int NLINES = 32,
  parameter int AUTO_DLY = 8,
  parameter logic [NLINES-1:0] DIRECT_MASK = {4'hF, {(NLINES-4){1'b0}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] trig_pulse,
  input  logic [NLINES-1:0] direct_lvl,
  input  logic [3:0]        clr_evt,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [NLINES-1:0] wake
);

  localparam int CNT_W = (AUTO_DLY > 1) ? $clog2(AUTO_DLY) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(AUTO_DLY - 1);

  logic [NLINES-1:0] en_q;
  logic [1:0]        code_q [NLINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      for (int i = 0; i < NLINES; i++) code_q[i] <= 2'b00;
    end else if (cfg_we) begin
      case (cfg_addr)
        2'd0: en_q <= cfg_wdata[NLINES-1:0];
        2'd1, 2'd2: begin
          for (int i = 0; i < NLINES; i++)
            if ((i < 16) == (cfg_addr == 2'd1))
              code_q[i] <= cfg_wdata[2*(i%16) +: 2];
        end
        default: begin
          for (int i = 0; i < NLINES; i++)
            if (cfg_wdata[i]) begin
              en_q[i]   <= 1'b0;
              code_q[i] <= 2'b00;
            end
        end
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      2'd0: cfg_rdata[NLINES-1:0] = en_q;
      2'd1, 2'd2: begin
        for (int i = 0; i < NLINES; i++)
          if ((i < 16) == (cfg_addr == 2'd1))
            cfg_rdata[2*(i%16) +: 2] = code_q[i];
      end
      default: cfg_rdata = '0;
    endcase
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic pend_q;
    logic sel_hit;
    assign sel_hit = clr_evt[code_q[g]];
    assign wake[g] = pend_q;

    if (DIRECT_MASK[g]) begin : g_dir
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              pend_q <= 1'b0;
        else if (direct_lvl[g])  pend_q <= 1'b1;
        else if (!en_q[g])       pend_q <= 1'b0;
        else if (sel_hit)        pend_q <= 1'b0;
      end

      AST_DIR_SET:   assert property (@(posedge clk) disable iff (!rst_n)
        direct_lvl[g] |=> wake[g]);                                      // R2
      AST_DIR_AUTO:  assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q[g] && !direct_lvl[g]) |=> !wake[g]);                      // R4
      AST_DIR_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        (wake[g] && en_q[g] && !sel_hit && !(cfg_we && cfg_addr != 2'd1 && cfg_addr != 2'd2)) |=> wake[g]); // R6
    end else begin : g_cfg
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pend_q <= 1'b0;
          cnt_q  <= '0;
        end else if (trig_pulse[g]) begin
          pend_q <= 1'b1;
          cnt_q  <= CNT_LOAD;
        end else if (pend_q) begin
          if (en_q[g]) begin
            if (sel_hit) pend_q <= 1'b0;
          end else if (cnt_q == '0) begin
            pend_q <= 1'b0;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
      end

      AST_TRIG_SET:   assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse[g] |=> wake[g]);                                      // R2
      AST_AUTO_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
        (wake[g] && !en_q[g] && cnt_q != '0 && !trig_pulse[g]) |=> wake[g]); // R3
      AST_EVT_CLEAR:  assert property (@(posedge clk) disable iff (!rst_n)
        (wake[g] && en_q[g] && sel_hit && !trig_pulse[g]) |=> !wake[g]); // R5
      AST_IDLE_STAY:  assert property (@(posedge clk) disable iff (!rst_n)
        (!wake[g] && !trig_pulse[g]) |=> !wake[g]);                      // R7
    end

    AST_CFG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == 2'd3 && cfg_wdata[g]) |=> (!en_q[g] && code_q[g] == 2'b00)); // R9
  end

endmodule

// File: tb/wkup_clear_sel_bench.sv
module wkup_clear_sel_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam int D = 3;
  localparam logic [N-1:0] DMASK = 32'hF000_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] trig_pulse = '0;
  logic [N-1:0] direct_lvl = '0;
  logic [3:0] clr_evt = '0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [N-1:0] wake;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wkup_clear_sel #(.NLINES(N), .AUTO_DLY(D), .DIRECT_MASK(DMASK)) u_wkup_clear_sel (
    .clk(clk), .rst_n(rst_n), .trig_pulse(trig_pulse), .direct_lvl(direct_lvl),
    .clr_evt(clr_evt), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .wake(wake));

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  function automatic logic [31:0] codes(int k, int base, logic [31:0] cleared);
    logic [31:0] v = '0;
    for (int i = 0; i < 16; i++)
      if (!cleared[base+i]) v[2*i +: 2] = 2'((base + i + k) % 4);
    return v;
  endfunction

  initial begin
    logic [31:0] r;
    logic [N-1:0] one;
    int c;
    #(CLK_PERIOD*2 + 1);
    chk("R1 wake at reset", wake, 0);
    rd(0, r); chk("R1 enables at reset", r, 0);
    rd(1, r); chk("R1 low codes at reset", r, 0);
    rd(2, r); chk("R1 high codes at reset", r, 0);
    @(negedge clk); rst_n = 1'b1;
    step();

    // automatic release, enables 0
    for (int L = 0; L < N; L++) begin
      one = N'(1) << L;
      if (DMASK[L]) begin
        direct_lvl = one; step();
        chk("R2 direct set", wake, one);
        for (int j = 0; j < D + 2; j++) begin step(); chk("R4 direct held high", wake, one); end
        direct_lvl = '0; step();
        chk("R4 direct drops after low", wake, 0);
      end else begin
        trig_pulse = one; step(); trig_pulse = '0;
        chk("R2 trigger set", wake, one);
        for (int j = 0; j < D - 1; j++) begin step(); chk("R3 auto hold", wake, one); end
        step(); chk("R3 auto drop after delay", wake, 0);
      end
    end

    // retrigger restarts delay
    one = N'(1) << 5;
    trig_pulse = one; step(); trig_pulse = '0; step();
    trig_pulse = one; step(); trig_pulse = '0;
    chk("R3 retrigger set", wake, one);
    for (int j = 0; j < D - 1; j++) begin step(); chk("R3 retrigger hold", wake, one); end
    step(); chk("R3 retrigger drop", wake, 0);

    // event release
    wr(0, 32'hFFFF_FFFF);
    rd(0, r); chk("R8 enable readback", r, 32'hFFFF_FFFF);
    clr_evt = 4'hF; step(); clr_evt = '0;
    chk("R7 idle strobes", wake, 0);
    for (int k = 0; k < 4; k++) begin
      wr(1, codes(k, 0, 0));
      wr(2, codes(k, 16, 0));
      rd(1, r); chk("R8 low code readback", r, codes(k, 0, 0));
      rd(2, r); chk("R8 high code readback", r, codes(k, 16, 0));
      for (int L = 0; L < N; L++) begin
        one = N'(1) << L;
        c = (L + k) % 4;
        if (DMASK[L]) begin
          direct_lvl = one; step();
          chk("R2 direct set evt mode", wake, one);
          direct_lvl = '0; step();
          chk("R6 direct holds after low", wake, one);
          clr_evt = 4'hF & ~(4'(1) << c); step();
          chk("R5 unselected strobes", wake, one);
          clr_evt = 4'(1) << c; step();
          chk("R5 selected strobe clears", wake, 0);
          step(); chk("R7 strobe while idle", wake, 0);
          clr_evt = '0;
        end else begin
          trig_pulse = one; step(); trig_pulse = '0;
          chk("R2 trigger set evt mode", wake, one);
          for (int j = 0; j < D + 1; j++) step();
          chk("R5 no auto drop when enabled", wake, one);
          clr_evt = 4'hF & ~(4'(1) << c); step();
          chk("R5 unselected strobes", wake, one);
          clr_evt = 4'(1) << c; trig_pulse = one; step(); trig_pulse = '0;
          chk("R2 trigger beats clear", wake, one);
          step(); chk("R5 selected strobe clears", wake, 0);
          step(); chk("R7 strobe while idle", wake, 0);
          clr_evt = '0;
        end
      end
    end

    // configuration clear, codes left at k=3
    wr(3, 32'h0010_00F0);
    rd(0, r); chk("R9 enables after clear", r, ~32'h0010_00F0);
    rd(1, r); chk("R9 low codes after clear", r, codes(3, 0, 32'h0010_00F0));
    rd(2, r); chk("R9 high codes after clear", r, codes(3, 16, 32'h0010_00F0));
    one = N'(1) << 4;
    trig_pulse = one; step(); trig_pulse = '0;
    for (int j = 0; j < D - 1; j++) step();
    step(); chk("R9 cleared line auto releases", wake, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule